// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a synthesizable cycle-level model of a byte-wide programmable read-only memory. A 19-bit address selects a byte. The operating mode is decoded from two active-low enables (`ce_n`, `oe_n`), a flag that stands for the high programming supply (`prog_hi`), and a flag that stands for the raised identifier voltage (`sig_mode`). The bidirectional data bus is split into an input byte (`din`) used for programming, an output byte (`dq_o`) and a drive enable (`dq_oe`). The drive enable is the tri-state control.

Programming is one-way. A write can only pull bits from one to zero, so the stored byte becomes the old value ANDed with the new one. Only the `erase` input, or reset (the delivered state), brings bits back to one. The array depth is a parameter, and addresses alias onto it. Analog access times are modelled as a fixed number of clock cycles (`ACC_LAT`).

Top module: `otp_byte_mem`

## Requirements
- R1: With `prog_hi`=0 and `ce_n`=1 (standby), `dq_oe` is 0 from the next clock edge on, whatever `oe_n` is.
- R2: With `prog_hi`=0, `ce_n`=0 and `oe_n`=1 (output disable), `dq_oe` is 0 from the next clock edge on.
- R3: With `prog_hi`=0, `sig_mode`=0 and both enables at 0 (read), `dq_o` carries the stored byte at the address and `dq_oe` is 1.
- R4: After reset, and after any cycle with `erase`=1, every location reads FFh. Erase takes priority over a write in the same cycle.
- R5: With `prog_hi`=1, `oe_n`=1 and `ce_n`=0, the first clock of each low pulse on `ce_n` stores old AND `din` at the address. Later clocks of the same pulse write nothing.
- R6: With `prog_hi`=1, `ce_n`=1 and `oe_n`=0 (verify), the stored byte at the address is driven out.
- R7: With `prog_hi`=1 and both enables equal (both 1, or both 0), nothing is written and `dq_oe` is 0.
- R8: With `sig_mode`=1, `prog_hi`=0 and both enables at 0, `dq_o` is 20h when `addr[0]`=0 and 41h when `addr[0]`=1.
- R9: When `prog_hi` and `sig_mode` are both 1, `proto_err` is 1 in the same cycle, no write happens and `dq_oe` is 0 from the next edge on.
- R10: `dq_oe` rises only after a driving mode has been sampled on `ACC_LAT` consecutive edges, and the data shown is the lookup from `ACC_LAT` edges earlier. `dq_oe` falls at the first edge after the driving mode ends.
- R11: Only the low log2(`DEPTH`) address bits select a location. Higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets every location to FFh |
| ce_n | input | 1 | Chip enable, active low; its low pulse is the program strobe |
| oe_n | input | 1 | Output enable, active low |
| prog_hi | input | 1 | High programming supply present |
| sig_mode | input | 1 | Identifier readout mode request |
| erase | input | 1 | Return every bit to one |
| addr | input | ADDR_W (19) | Byte address |
| din | input | DATA_W (8) | Byte to program |
| dq_o | output | DATA_W (8) | Output byte; zero while not driven |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |
| proto_err | output | 1 | Supply and identifier flags asserted together |

## Verification
The bound checker watches the undriven states on every cycle: standby, output disable, program inhibit and the protocol fault must all leave the bus released one edge later. It also checks that a driven bus is always preceded by an active output enable. Stored contents can only be seen through later reads, so only the bench's scenarios can show these behaviours: the AND-only programming, one write per strobe, erase priority, the identifier bytes, address aliasing and the exact access latency.

// File: rtl/otp_pkg.sv
package otp_pkg;

   typedef enum logic [2:0] {
      M_STANDBY,
      M_OFF,
      M_READ,
      M_IDENT,
      M_PROG,
      M_VERIFY,
      M_INHIBIT,
      M_FAULT
   } otp_mode_t;

   function automatic logic mode_drives(input otp_mode_t m);
      return (m == M_READ) || (m == M_IDENT) || (m == M_VERIFY);
   endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
   import otp_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      prog_hi,
   input  logic      sig_mode,
   output otp_mode_t mode,
   output logic      drive,
   output logic      wr_level,
   output logic      fault
);

   always_comb begin
      if (prog_hi && sig_mode) begin
         mode = M_FAULT;
      end else if (prog_hi) begin
         case ({ce_n, oe_n})
            2'b01:   mode = M_PROG;
            2'b10:   mode = M_VERIFY;
            default: mode = M_INHIBIT;
         endcase
      end else if (ce_n) begin
         mode = M_STANDBY;
      end else if (oe_n) begin
         mode = M_OFF;
      end else begin
         mode = sig_mode ? M_IDENT : M_READ;
      end
   end

   assign drive    = mode_drives(mode);
   assign wr_level = (mode == M_PROG);
   assign fault    = (mode == M_FAULT);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              wr_level,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] cells [DEPTH];
   logic              wr_prev;
   logic              wr_strobe;

   assign wr_strobe = wr_level && !wr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            cells[i] <= '1;
         end
      end else begin
         wr_prev <= wr_level;
         if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
               cells[i] <= '1;
            end
         end else if (wr_strobe) begin
            cells[idx] <= cells[idx] & wr_data;
         end
      end
   end

   assign rd_data = cells[idx];

endmodule

// File: rtl/otp_read_pipe.sv
module otp_read_pipe #(
   parameter int DATA_W = 8,
   parameter int LAT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive,
   input  logic [DATA_W-1:0] din,
   output logic              q_oe,
   output logic [DATA_W-1:0] q
);

   logic [LAT-1:0]    vld;
   logic [DATA_W-1:0] stg [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld[0] <= 1'b0;
         stg[0] <= '0;
      end else begin
         vld[0] <= drive;
         stg[0] <= din;
      end
   end

   for (genvar gi = 1; gi < LAT; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[gi] <= 1'b0;
            stg[gi] <= '0;
         end else begin
            vld[gi] <= vld[gi-1] && drive;
            stg[gi] <= stg[gi-1];
         end
      end
   end

   assign q_oe = vld[LAT-1];
   assign q    = vld[LAT-1] ? stg[LAT-1] : '0;

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
   import otp_pkg::*;
#(
   parameter int                ADDR_W   = 19,
   parameter int                DATA_W   = 8,
   parameter int                DEPTH    = 256,
   parameter int                ACC_LAT  = 2,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h41
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              prog_hi,
   input  logic              sig_mode,
   input  logic              erase,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic              proto_err
);

   localparam int IDX_W = $clog2(DEPTH);

   if (ACC_LAT < 1) begin : g_bad_lat
      $fatal(1, "ACC_LAT must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $fatal(1, "DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $fatal(1, "DEPTH exceeds the address space");
   end
   if (DATA_W < 1) begin : g_bad_data
      $fatal(1, "DATA_W must be positive");
   end

   otp_mode_t         mode;
   logic              drive;
   logic              wr_level;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] cell_q;
   logic [DATA_W-1:0] lookup;
   logic              unused_addr_hi;

   assign idx            = addr[IDX_W-1:0];
   assign unused_addr_hi = ^addr;

   otp_mode_dec u_dec (
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .prog_hi  (prog_hi),
      .sig_mode (sig_mode),
      .mode     (mode),
      .drive    (drive),
      .wr_level (wr_level),
      .fault    (proto_err)
   );

   otp_cell_array #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .erase    (erase),
      .wr_level (wr_level),
      .idx      (idx),
      .wr_data  (din),
      .rd_data  (cell_q)
   );

   always_comb begin
      if (mode == M_IDENT) begin
         lookup = addr[0] ? DEV_CODE : MFR_CODE;
      end else begin
         lookup = cell_q;
      end
   end

   otp_read_pipe #(
      .DATA_W (DATA_W),
      .LAT    (ACC_LAT)
   ) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .drive (drive),
      .din   (lookup),
      .q_oe  (dq_oe),
      .q     (dq_o)
   );

endmodule

// File: rtl/otp_byte_mem_chk.sv
module otp_byte_mem_chk (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic oe_n,
   input logic prog_hi,
   input logic dq_oe,
   input logic proto_err
);

   assert_standby_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_hi && ce_n) |=> !dq_oe);

   assert_disable_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_hi && !ce_n && oe_n) |=> !dq_oe);

   assert_inhibit_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_hi && (ce_n == oe_n)) |=> !dq_oe);

   assert_fault_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> !dq_oe);

   assert_drive_needs_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> $past(!oe_n));

endmodule

bind otp_byte_mem otp_byte_mem_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .oe_n      (oe_n),
   .prog_hi   (prog_hi),
   .dq_oe     (dq_oe),
   .proto_err (proto_err)
);

// File: tb/otp_byte_mem_test.sv
`timescale 1ns/1ps
module otp_byte_mem_test;

   localparam int AW  = 19;
   localparam int DW  = 8;
   localparam int DEP = 256;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          prog_hi = 1'b0;
   logic          sig_mode = 1'b0;
   logic          erase = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dq_o;
   logic          dq_oe;
   logic          proto_err;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   otp_byte_mem #(
      .ADDR_W  (AW),
      .DATA_W  (DW),
      .DEPTH   (DEP),
      .ACC_LAT (LAT)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .prog_hi   (prog_hi),
      .sig_mode  (sig_mode),
      .erase     (erase),
      .addr      (addr),
      .din       (din),
      .dq_o      (dq_o),
      .dq_oe     (dq_oe),
      .proto_err (proto_err)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=<100000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pins(input logic c, input logic o, input logic p, input logic s,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
      ce_n = c; oe_n = o; prog_hi = p; sig_mode = s; addr = a; din = d;
   endtask

   task automatic idle();
      pins(1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
      step(1);
   endtask

   // returns {dq_oe, dq_o} after LAT edges in read mode
   task automatic read_at(input logic [AW-1:0] a, output logic [8:0] r);
      pins(1'b0, 1'b0, 1'b0, 1'b0, a, '0);
      step(LAT);
      r = {dq_oe, dq_o};
      idle();
   endtask

   task automatic verify_at(input logic [AW-1:0] a, output logic [8:0] r);
      pins(1'b1, 1'b0, 1'b1, 1'b0, a, '0);
      step(LAT);
      r = {dq_oe, dq_o};
      idle();
   endtask

   task automatic program_at(input logic [AW-1:0] a, input logic [DW-1:0] d);
      pins(1'b0, 1'b1, 1'b1, 1'b0, a, d);
      step(1);
      ce_n = 1'b1;
      step(1);
      idle();
   endtask

   task automatic t_reset();
      logic [8:0] r;
      check("R4 reset dq_oe", {15'd0, dq_oe}, 16'd0);
      check("R9 reset proto_err", {15'd0, proto_err}, 16'd0);
      read_at(19'd5, r);
      check("R4 R3 blank read", {7'd0, r}, {7'd0, 9'h1FF});
   endtask

   task automatic t_program();
      logic [8:0] r;
      program_at(19'd3, 8'hA5);
      read_at(19'd3, r);
      check("R5 R3 first write", {7'd0, r}, {7'd0, 9'h1A5});
      program_at(19'd3, 8'h0F);
      read_at(19'd3, r);
      check("R5 AND write", {7'd0, r}, {7'd0, 9'h105});
      program_at(19'd3, 8'hFF);
      read_at(19'd3, r);
      check("R5 ones keep zeros", {7'd0, r}, {7'd0, 9'h105});
   endtask

   task automatic t_one_per_pulse();
      logic [8:0] r;
      pins(1'b0, 1'b1, 1'b1, 1'b0, 19'd7, 8'hF0);
      step(1);
      din = 8'h0F;
      step(2);
      ce_n = 1'b1;
      step(1);
      idle();
      read_at(19'd7, r);
      check("R5 single write per pulse", {7'd0, r}, {7'd0, 9'h1F0});
   endtask

   task automatic t_verify();
      logic [8:0] r;
      verify_at(19'd3, r);
      check("R6 verify", {7'd0, r}, {7'd0, 9'h105});
   endtask

   task automatic t_inhibit();
      logic [8:0] r;
      pins(1'b1, 1'b1, 1'b1, 1'b0, 19'd9, 8'h00);
      step(3);
      check("R7 inhibit float", {15'd0, dq_oe}, 16'd0);
      pins(1'b0, 1'b0, 1'b1, 1'b0, 19'd9, 8'h00);
      step(3);
      check("R7 both low float", {15'd0, dq_oe}, 16'd0);
      idle();
      read_at(19'd9, r);
      check("R7 no write", {7'd0, r}, {7'd0, 9'h1FF});
   endtask

   task automatic t_enables();
      pins(1'b0, 1'b0, 1'b0, 1'b0, 19'd3, '0);
      if (LAT > 1) begin
         step(LAT - 1);
         check("R10 not before latency", {15'd0, dq_oe}, 16'd0);
         step(1);
      end else begin
         step(1);
      end
      check("R10 R3 at latency", {7'd0, dq_oe, dq_o}, {7'd0, 9'h105});
      oe_n = 1'b1;
      step(1);
      check("R2 R10 release after oe rise", {15'd0, dq_oe}, 16'd0);
      oe_n = 1'b0;
      step(LAT);
      check("R3 drive again", {15'd0, dq_oe}, 16'd1);
      ce_n = 1'b1;
      step(1);
      check("R1 standby with oe low", {15'd0, dq_oe}, 16'd0);
      idle();
   endtask

   task automatic t_ident();
      pins(1'b0, 1'b0, 1'b0, 1'b1, 19'd0, '0);
      step(LAT);
      check("R8 manufacturer byte", {7'd0, dq_oe, dq_o}, {7'd0, 9'h120});
      addr = 19'd1;
      step(LAT);
      check("R8 device byte", {7'd0, dq_oe, dq_o}, {7'd0, 9'h141});
      idle();
   endtask

   task automatic t_fault();
      logic [8:0] r;
      pins(1'b0, 1'b1, 1'b1, 1'b1, 19'd11, 8'h00);
      #1;
      check("R9 flag same cycle", {15'd0, proto_err}, 16'd1);
      step(2);
      check("R9 no drive", {15'd0, dq_oe}, 16'd0);
      idle();
      read_at(19'd11, r);
      check("R9 no write", {7'd0, r}, {7'd0, 9'h1FF});
   endtask

   task automatic t_alias();
      logic [8:0] r;
      program_at(19'd268, 8'h3C);
      read_at(19'd12, r);
      check("R11 high bits ignored", {7'd0, r}, {7'd0, 9'h13C});
   endtask

   task automatic t_erase();
      logic [8:0] r;
      erase = 1'b1;
      pins(1'b0, 1'b1, 1'b1, 1'b0, 19'd20, 8'h00);
      step(1);
      erase = 1'b0;
      ce_n = 1'b1;
      step(1);
      idle();
      read_at(19'd20, r);
      check("R4 erase beats write", {7'd0, r}, {7'd0, 9'h1FF});
      read_at(19'd3, r);
      check("R4 erase restores", {7'd0, r}, {7'd0, 9'h1FF});
      read_at(19'd12, r);
      check("R4 erase restores alias", {7'd0, r}, {7'd0, 9'h1FF});
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_program();
      t_one_per_pulse();
      t_verify();
      t_inhibit();
      t_enables();
      t_ident();
      t_fault();
      t_alias();
      t_erase();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule